// File: doc/BRIEF.md
# Melody note sequencer

This block plays a tune stored as a list of 16-bit note words in a memory it does not own. Once started, it reads the words one by one through a request/acknowledge read port. It turns each word into a square wave of a given half-period, and it holds that tone for a length set by a per-note code multiplied by a base unit that comes from a global tempo setting. A note word whose length code is zero ends the tune. The block then pulses a one-clock end flag and goes idle.

The word for the next note is fetched while the current note is still sounding. Consecutive notes therefore follow each other with no idle clock, provided the memory answers before the current note runs out. If the memory is slower than that, the output stays low until the word arrives. A half-period of zero gives a rest. Dropping the run control, or setting tempo to zero, stops playback on the next clock.

Top module: `mel_seq`

## Requirements
- R1: While `rst` is high and on the clock after it, `tone_out`, `mel_end` and `rd_req` are low.
- R2: Playback starts on a clock where `run` is high, it was low on the previous clock, and `tempo` is non-zero. The first read uses address 0, and each later word comes from the previous address plus one.
- R3: A note word carries its length code in bits 15:10 and its half-period divisor D in bits 9:0. For a non-zero D, `tone_out` is low for the first D clocks of the note and then changes level every D clocks.
- R4: A note with length code L lasts exactly L × (16 − tempo) × BASE_UNIT clocks. `tempo` is sampled on the clock where the note begins, so tempo 1 is the slowest setting and tempo 15 the fastest.
- R5: A note with D = 0 is a rest: `tone_out` stays low for the whole duration.
- R6: The read for the following word is raised on the clock after a note begins. If that word has arrived by the end of the note, the next note begins on the very next clock, with no gap.
- R7: If the next word has not arrived when a note ends, `tone_out` is held low until the acknowledge comes, and the note begins on the clock after it.
- R8: A word with length code 0 ends the tune. `tone_out` goes low, `mel_end` is high for exactly one clock, no further read is made, and a new start needs `run` to fall and rise again.
- R9: If `run` is low during playback, playback stops on the next clock: `tone_out` and `rd_req` go low and `mel_end` is not raised.
- R10: If `tempo` is 0 during playback, playback stops in the same way as for R9. A rising `run` while `tempo` is 0 does not start playback.
- R11: `rd_req` stays high with a stable `rd_addr` until `rd_ack` is seen. `rd_data` is taken on the clock where `rd_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start on a rising level; stop when low |
| tempo | input | 4 | Tempo setting, 1 slowest to 15 fastest; 0 stops |
| rd_req | output | 1 | Read request to note memory |
| rd_addr | output | ADDR_W | Note word address |
| rd_ack | input | 1 | Read acknowledge, with data valid |
| rd_data | input | 16 | Note word |
| tone_out | output | 1 | Square-wave output |
| mel_end | output | 1 | One-clock pulse when the end code is read |

## Verification
The hardest case to reach is a note that ends on the same clock as the acknowledge for its successor, and, close to it, a note that ends before its successor has been fetched. The bench memory model has a latency setting that the test changes per scenario. Very short notes (a length code of 1 at the fastest tempo) are combined with latencies both below and above the note duration. This makes the prefetched word arrive early, exactly at the boundary, or late. A tempo change during playback is also used, so the model can check that tempo is sampled per note.

// File: rtl/mel_pkg.sv
package mel_pkg;

    localparam int WORD_W  = 16;
    localparam int LEN_W   = 6;
    localparam int DIV_W   = 10;
    localparam int TEMPO_W = 4;

    localparam int LEN_MAX   = (1 << LEN_W) - 1;
    localparam int TEMPO_MAX = (1 << TEMPO_W) - 1;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] div;
    } note_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PLAY = 2'd2
    } seq_state_t;

    // Number of base units per length step: 15 at tempo 1, 1 at tempo 15.
    function automatic logic [TEMPO_W:0] tempo_steps(input logic [TEMPO_W-1:0] t);
        return (TEMPO_W+1)'(1 << TEMPO_W) - {1'b0, t};
    endfunction

endpackage

// File: rtl/mel_fetch.sv
module mel_fetch
    import mel_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              start,
    input  logic              issue,
    input  logic              take,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              have_word,
    output logic [WORD_W-1:0] word
);

    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] hold_q;
    logic              hold_vld_q;
    logic              arrive;

    assign arrive = req_q && rd_ack;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            req_q      <= 1'b0;
            addr_q     <= '0;
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
        end else if (start) begin
            req_q      <= 1'b1;
            addr_q     <= '0;
            hold_vld_q <= 1'b0;
        end else begin
            if (arrive) begin
                addr_q <= addr_q + 1'b1;
                req_q  <= 1'b0;
                if (!take) begin
                    hold_q     <= rd_data;
                    hold_vld_q <= 1'b1;
                end
            end
            if (take && hold_vld_q) begin
                hold_vld_q <= 1'b0;
            end
            if (issue) begin
                req_q <= 1'b1;
            end
        end
    end

    assign have_word = hold_vld_q || arrive;
    assign word      = hold_vld_q ? hold_q : rd_data;
    assign rd_req    = req_q;
    assign rd_addr   = addr_q;

endmodule

// File: rtl/mel_tone_timer.sv
module mel_tone_timer
    import mel_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic             load,
    input  logic [DUR_W-1:0] dur_m1,
    input  logic [DIV_W-1:0] half_div,
    output logic             tone,
    output logic             last,
    output logic [DIV_W-1:0] cur_div
);

    logic             active_q;
    logic [DUR_W-1:0] left_q;
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] div_q;
    logic             tone_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            left_q   <= '0;
            ph_q     <= '0;
            div_q    <= '0;
            tone_q   <= 1'b0;
        end else if (stop) begin
            active_q <= 1'b0;
            left_q   <= '0;
            tone_q   <= 1'b0;
        end else if (load) begin
            active_q <= 1'b1;
            left_q   <= dur_m1;
            ph_q     <= '0;
            div_q    <= half_div;
            tone_q   <= 1'b0;
        end else if (active_q && left_q != '0) begin
            left_q <= left_q - 1'b1;
            if (div_q != '0) begin
                if (ph_q == div_q - 1'b1) begin
                    ph_q   <= '0;
                    tone_q <= ~tone_q;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign tone    = tone_q;
    assign last    = active_q && (left_q == '0);
    assign cur_div = div_q;

endmodule

// File: rtl/mel_seq.sv
module mel_seq
    import mel_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_UNIT = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [TEMPO_W-1:0] tempo,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_ack,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               tone_out,
    output logic               mel_end
);

    localparam int MAX_DUR = LEN_MAX * TEMPO_MAX * BASE_UNIT;
    localparam int DUR_W   = $clog2(MAX_DUR + 1);

    seq_state_t        st_q, st_d;
    logic              run_q;
    logic              end_q;

    logic              have_word;
    logic [WORD_W-1:0] word;
    note_t             nw;

    logic abort, start, boundary, want, take, is_end, load, stop;
    logic last;
    logic [DUR_W-1:0] dur_full;
    logic [DUR_W-1:0] dur_m1;
    logic [DIV_W-1:0] note_div;
    logic             busy;
    logic             in_play;
    logic             in_wait;

    assign nw = note_t'(word);

    assign busy     = (st_q != ST_IDLE);
    assign in_play  = (st_q == ST_PLAY);
    assign in_wait  = (st_q == ST_WAIT);

    assign abort    = busy && (!run || tempo == '0);
    assign start    = !busy && run && !run_q && (tempo != '0);
    assign boundary = in_play && last;
    assign want     = in_wait || boundary;
    assign take     = !abort && want && have_word;
    assign is_end   = take && (nw.len == '0);
    assign load     = take && (nw.len != '0);
    assign stop     = abort || is_end || (boundary && !have_word);

    assign dur_full = DUR_W'(nw.len) * DUR_W'(tempo_steps(tempo)) * DUR_W'(BASE_UNIT);
    assign dur_m1   = dur_full - 1'b1;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d = ST_IDLE;
        end else if (start) begin
            st_d = ST_WAIT;
        end else if (is_end) begin
            st_d = ST_IDLE;
        end else if (load) begin
            st_d = ST_PLAY;
        end else if (boundary) begin
            st_d = ST_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            run_q <= 1'b0;
            end_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            run_q <= run;
            end_q <= is_end;
        end
    end

    mel_fetch #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .clr       (abort),
        .start     (start),
        .issue     (load),
        .take      (take),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .have_word (have_word),
        .word      (word)
    );

    mel_tone_timer #(
        .DUR_W (DUR_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .load     (load),
        .dur_m1   (dur_m1),
        .half_div (nw.div),
        .tone     (tone_out),
        .last     (last),
        .cur_div  (note_div)
    );

    assign mel_end = end_q;

endmodule

// File: rtl/mel_seq_chk.sv
module mel_seq_chk
    import mel_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic [TEMPO_W-1:0] tempo,
    input logic               rd_req,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               rd_ack,
    input logic               tone_out,
    input logic               mel_end,
    input logic               busy,
    input logic               in_play,
    input logic               in_wait,
    input logic [DIV_W-1:0]   note_div
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q) begin
            reset_quiet_chk: assert (!tone_out && !mel_end && !rd_req)
                else $error("outputs active right after reset");
        end
    end

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (rd_req && rd_addr == '0));

    // R5
    rest_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_play && note_div == '0) |-> !tone_out);

    // R7
    wait_low_chk: assert property (@(posedge clk) disable iff (rst)
        in_wait |-> !tone_out);

    // R8
    end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mel_end |-> (!tone_out && !rd_req && !busy));

    // R8
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        mel_end |=> !mel_end);

    // R9
    run_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !run) |=> (!tone_out && !rd_req && !busy && !mel_end));

    // R10
    tempo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tempo == '0) |=> (!busy && !rd_req && !mel_end));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && run && tempo != '0) |=> (rd_req && $stable(rd_addr)));

endmodule

bind mel_seq mel_seq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tempo    (tempo),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .tone_out (tone_out),
    .mel_end  (mel_end),
    .busy     (busy),
    .in_play  (in_play),
    .in_wait  (in_wait),
    .note_div (note_div)
);

// File: tb/test_mel_seq.sv
`timescale 1ns/1ps
module test_mel_seq;

    localparam int AW = 8;
    localparam int BU = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic [3:0]    tempo = 4'd15;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [15:0]   rd_data = 16'h0;
    logic          tone_out;
    logic          mel_end;

    always #2.5 clk = ~clk;

    mel_seq #(.ADDR_W(AW), .BASE_UNIT(BU)) i_mel_seq (
        .clk(clk), .rst(rst), .run(run), .tempo(tempo),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .tone_out(tone_out), .mel_end(mel_end)
    );

    logic [15:0] mem [256];
    int mem_lat = 0;
    int mem_cnt = 0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int end_cnt = 0;
    int req_rises = 0;
    bit started = 0;
    bit prev_req = 0;

    // behavioural reference
    int          m_state = 0;   // 0 idle, 1 waiting for word, 2 sounding
    int          m_k = 0, m_n = 0, m_d = 0;
    bit          m_out = 0, m_end = 0, m_req = 0, m_runq = 0, m_hasnext = 0;
    logic [7:0]  m_addr = 0;
    logic [15:0] m_next = 0;

    function automatic logic [15:0] note(input int len, input int d);
        return {len[5:0], d[9:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic begin_note(input logic [15:0] w);
        if (w[15:10] == 6'd0) begin
            m_state = 0; m_out = 0; m_end = 1; m_req = 0;
        end else begin
            m_state = 2; m_k = 0; m_out = 0; m_req = 1;
            m_n = int'(w[15:10]) * (16 - int'(tempo)) * BU;
            m_d = int'(w[9:0]);
        end
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_state = 0; m_out = 0; m_end = 0; m_req = 0; m_runq = 0;
            m_hasnext = 0; m_addr = 0; m_k = 0;
        end else begin
            bit ackn;
            ackn = rd_ack && m_req;
            m_end = 0;
            if (m_state != 0 && (!run || tempo == 0)) begin
                m_state = 0; m_out = 0; m_req = 0; m_hasnext = 0; m_addr = 0;
            end else begin
                case (m_state)
                    0: if (run && !m_runq && tempo != 0) begin
                        m_state = 1; m_addr = 0; m_req = 1; m_hasnext = 0; m_out = 0;
                    end
                    1: if (ackn) begin
                        logic [15:0] w;
                        w = mem[m_addr]; m_addr++; m_req = 0;
                        begin_note(w);
                    end
                    default: begin
                        if (m_k == m_n - 1) begin
                            if (m_hasnext) begin
                                m_hasnext = 0; begin_note(m_next);
                            end else if (ackn) begin
                                logic [15:0] w;
                                w = mem[m_addr]; m_addr++; m_req = 0;
                                begin_note(w);
                            end else begin
                                m_state = 1; m_out = 0;
                            end
                        end else begin
                            m_k++;
                            m_out = (m_d != 0) && (((m_k / m_d) % 2) == 1);
                            if (ackn) begin
                                m_next = mem[m_addr]; m_hasnext = 1; m_addr++; m_req = 0;
                            end
                        end
                    end
                endcase
            end
            m_runq = run;
        end
    end

    // compare, then advance the memory model
    always @(negedge clk) begin
        cyc++;
        if (started) begin
            chk(tone_out === m_out, "R3 R4 R5 R6 R7 R9 tone_out", int'(tone_out), int'(m_out));
            chk(mel_end === m_end, "R8 mel_end", int'(mel_end), int'(m_end));
            chk(rd_req === m_req, "R2 R6 R9 R11 rd_req", int'(rd_req), int'(m_req));
            if (m_req)
                chk(rd_addr === m_addr, "R2 R11 rd_addr", int'(rd_addr), int'(m_addr));
        end
        if (mel_end === 1'b1) end_cnt++;
        if (rd_req === 1'b1 && !prev_req) req_rises++;
        prev_req = (rd_req === 1'b1);
        if (rd_req !== 1'b1) begin
            rd_ack = 0; mem_cnt = 0;
        end else if (rd_ack) begin
            rd_ack = 0; mem_cnt = 0;
        end else if (mem_cnt >= mem_lat) begin
            rd_ack = 1; rd_data = mem[rd_addr];
        end else begin
            mem_cnt++;
        end
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_end(input int maxc, input string tag);
        int e0;
        e0 = end_cnt;
        for (int i = 0; i < maxc && end_cnt == e0; i++) @(negedge clk);
        chk(end_cnt == e0 + 1, tag, end_cnt - e0, 1);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    endtask

    initial begin
        int r0, e0;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(tone_out === 1'b0 && mel_end === 1'b0 && rd_req === 1'b0, "R1 reset outputs",
            int'(tone_out) + int'(mel_end) + int'(rd_req), 0);
        rst = 0;
        repeat (2) @(negedge clk);

        // Melody with rest, D=1, short notes, fast tempo
        mem[0] = note(2, 3); mem[1] = note(1, 1); mem[2] = note(3, 0);
        mem[3] = note(2, 5); mem[4] = note(1, 2); mem[5] = 16'h0;
        tempo = 15; mem_lat = 1;
        run = 1;
        wait_end(2000, "R8 end pulse after melody A");
        r0 = req_rises;
        repeat (20) @(negedge clk);
        // R8: no more reads and no restart while run stays high
        chk(req_rises == r0 && rd_req === 1'b0, "R8 idle after end", req_rises - r0, 0);
        run = 0;
        repeat (4) @(negedge clk);

        // Slow tempo
        clear_mem();
        mem[0] = note(1, 4); mem[1] = note(2, 7); mem[2] = 16'h0;
        tempo = 1; mem_lat = 2;
        run = 1;
        wait_end(5000, "R4 end after slow-tempo melody");
        run = 0;
        repeat (4) @(negedge clk);

        // Memory slower than notes: gaps (R7) and boundary arrivals (R6)
        for (int lat = 1; lat <= 12; lat += 3) begin
            clear_mem();
            mem[0] = note(1, 1); mem[1] = note(1, 2); mem[2] = note(2, 0);
            mem[3] = note(1, 1); mem[4] = 16'h0;
            tempo = 15; mem_lat = lat;
            run = 1;
            wait_end(2000, "R7 end with slow memory");
            run = 0;
            repeat (4) @(negedge clk);
        end

        // Tempo change mid-melody, then abort by run low
        clear_mem();
        for (int i = 0; i < 40; i++) mem[i] = note(3 + (i % 4), 1 + (i % 6));
        tempo = 15; mem_lat = 0;
        run = 1;
        repeat (15) @(negedge clk);
        tempo = 8;
        repeat (150) @(negedge clk);
        e0 = end_cnt;
        run = 0;
        @(negedge clk);
        @(negedge clk);
        chk(tone_out === 1'b0 && rd_req === 1'b0, "R9 run low stops",
            int'(tone_out) + int'(rd_req), 0);
        chk(end_cnt == e0, "R9 no end flag on abort", end_cnt - e0, 0);
        repeat (4) @(negedge clk);

        // Abort by tempo 0
        tempo = 12;
        run = 1;
        repeat (60) @(negedge clk);
        e0 = end_cnt;
        tempo = 0;
        @(negedge clk);
        @(negedge clk);
        chk(tone_out === 1'b0 && rd_req === 1'b0, "R10 tempo 0 stops",
            int'(tone_out) + int'(rd_req), 0);
        chk(end_cnt == e0, "R10 no end flag on tempo stop", end_cnt - e0, 0);
        run = 0;
        repeat (4) @(negedge clk);

        // Rising run with tempo 0 must not start
        r0 = req_rises;
        run = 1;
        repeat (20) @(negedge clk);
        chk(req_rises == r0, "R10 no start at tempo 0", req_rises - r0, 0);
        run = 0;
        tempo = 5;
        repeat (4) @(negedge clk);

        // Immediate end code
        clear_mem();
        mem_lat = 3;
        run = 1;
        wait_end(100, "R8 end on first word");
        chk(tone_out === 1'b0, "R8 output low at end", int'(tone_out), 0);
        run = 0;
        repeat (4) @(negedge clk);

        // Restart after end plays again from address 0
        mem[0] = note(2, 2); mem[1] = 16'h0;
        tempo = 14;
        run = 1;
        wait_end(500, "R2 restart from address 0");
        run = 0;
        repeat (6) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule